// File: doc/BRIEF.md
# Dual-Timer Pulse-Width Modulator

Two down-counting timers sit behind a plain register port. Each timer has a control word, a reload value and a readable counter. A timer can run alone: it counts down, raises a terminal event when its counter passes zero and, if automatic reload is on, starts again from its reload value. When its event output is enabled, each terminal event appears as a one-cycle pulse on that timer's event pin.

When both control words carry the full pulse-width configuration, the pair drives one modulated output. Timer 0 fixes the period. Timer 1 fixes how long the output stays high. Each terminal event of timer 0 restarts both timers together. Software changes the waveform by rewriting the two reload values. A new value is used only at the next reload, and the two writes are separate. One period can therefore combine the new period with the old high time.

Top module: `dual_timer_pwm`

## Requirements
- R1: Register map, word address `bus_addr`: bit 2 selects the timer, and bits 1:0 select control (0), reload value (1) or counter (2, read-only). Code 3 reads zero. Control bits: 0 event mode, 1 auto-reload, 2 load, 3 event-output enable, 4 run enable, 5 pulse-width mode, 6 chaining. Control bits 31:7 read as zero. `bus_rdata` reflects the addressed register in the same cycle.
- R2: While the load bit is set, the counter holds the reload value and does not count.
- R3: With run enable set and load clear, the counter falls by one each cycle. A terminal event occurs in the cycle its value is zero. Without auto-reload the counter then wraps to all-ones and keeps counting.
- R4: With auto-reload, the counter shows all-ones for one cycle after a terminal event and then the reload value, so a reload value L gives a timer cycle of L+2 clocks.
- R5: With event mode and event-output enable both set, each terminal event gives a one-clock pulse on that timer's `evt_out` bit in the following cycle. With the output enable clear, no pulse appears.
- R6: `pwm_out` is low in every cycle in which either control word lacks event mode, auto-reload, event-output enable, run enable or pulse-width mode, or has load or chaining set.
- R7: In pulse-width operation, `pwm_out` repeats every L0+2 clocks, where L0 is timer 0's reload value.
- R8: The high time per period is min(L1, L0)+1 clocks, where L1 is timer 1's reload value. At least one low clock therefore falls in every period, whatever values are programmed.
- R9: A reload value written mid-period takes effect only at the next reload. If the timer-0 value changes before a reload and the timer-1 value after it, that one period has the new length and the old high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_out | output | 2 | Per-timer terminal-event pulses |
| pwm_out | output | 1 | Modulated output |

## Verification
Several faults show up as wrong edge spacing on `pwm_out` within one period: a counter stepping wrongly, skipping the all-ones reload cycle, or failing to reload timer 1 at timer 0's terminal event. The bench therefore measures high time and period over several reload pairs, including equal values, a zero value and a duty value above the period value. A corrupted mode decode shows at the ports as a high level right after the offending control write. A corrupted counter or load hold shows at the next counter read, one clock later.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
   localparam int CTL_BITS = 7;

   // bit 0 is the least significant field
   typedef struct packed {
      logic chain;    // 6
      logic pwm_md;   // 5
      logic run;      // 4
      logic evt_oe;   // 3
      logic ld;       // 2
      logic arl;      // 1
      logic evt_md;   // 0
   } ctl_t;

   function automatic logic pwm_ready(input ctl_t c);
      return c.evt_md && c.arl && !c.ld && c.evt_oe && c.run && c.pwm_md && !c.chain;
   endfunction
endpackage

// File: rtl/dtp_timer.sv
module dtp_timer
   import dtp_pkg::*;
#(
   parameter int  CW      = 32,
   parameter int  DW      = 32,
   parameter bit  REG_EVT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ctl,
   input  logic          wr_load,
   input  logic [DW-1:0] wdata,
   input  logic          sync_rl,
   output ctl_t          ctl_o,
   output logic [CW-1:0] load_o,
   output logic [CW-1:0] cnt_o,
   output logic          tc_o,
   output logic          rl_o,
   output logic          evt_o
);
   localparam logic [CW-1:0] ZERO = '0;

   ctl_t          ctl_q;
   logic [CW-1:0] load_q, cnt_q;
   logic          rl_pend, counting, tc;

   if (CW < 2 || CW > DW) begin : g_bad_width
      $error("dtp_timer: CW must lie in 2..DW");
   end

   assign counting = ctl_q.run && !ctl_q.ld;
   assign tc       = counting && !rl_pend && (cnt_q == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         load_q <= '0;
      end else begin
         if (wr_ctl)  ctl_q  <= ctl_t'(wdata[CTL_BITS-1:0]);
         if (wr_load) load_q <= wdata[CW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rl_pend <= 1'b0;
      end else begin
         if (ctl_q.ld) begin
            cnt_q   <= load_q;
            rl_pend <= 1'b0;
         end else if (rl_pend) begin
            cnt_q   <= load_q;
            rl_pend <= 1'b0;
         end else if (counting) begin
            cnt_q <= cnt_q - 1'b1;
            if (tc && ctl_q.arl) rl_pend <= 1'b1;
         end
         if (sync_rl && !ctl_q.ld) rl_pend <= 1'b1;
      end
   end

   if (REG_EVT) begin : g_evt_reg
      logic evt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) evt_q <= 1'b0;
         else        evt_q <= tc && ctl_q.evt_md && ctl_q.evt_oe;
      end
      assign evt_o = evt_q;
   end else begin : g_evt_comb
      assign evt_o = tc && ctl_q.evt_md && ctl_q.evt_oe;
   end

   assign ctl_o  = ctl_q;
   assign load_o = load_q;
   assign cnt_o  = cnt_q;
   assign tc_o   = tc;
   assign rl_o   = rl_pend;

   AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.ld |=> cnt_q == $past(load_q));                            // R2
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && !rl_pend) |=> cnt_q == CW'($past(cnt_q) - 1'b1));    // R3
   AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (rl_pend && !ctl_q.ld) |=> cnt_q == $past(load_q));              // R4
endmodule

// File: rtl/dtp_pwm_shaper.sv
module dtp_pwm_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tc_per,
   input  logic rl_per,
   input  logic tc_duty,
   output logic pwm_o
);
   logic pwm_q;

   // priority: leave mode, period end, duty end, period start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pwm_q <= 1'b0;
      else if (!active)  pwm_q <= 1'b0;
      else if (tc_per)   pwm_q <= 1'b0;
      else if (tc_duty)  pwm_q <= 1'b0;
      else if (rl_per)   pwm_q <= 1'b1;
   end

   assign pwm_o = pwm_q && active;

   AST_LOW_AFTER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      tc_per |=> !pwm_o);                                              // R8
   AST_LOW_AFTER_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      tc_duty |=> !pwm_o);                                             // R8
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
   import dtp_pkg::*;
#(
   parameter int CW      = 32,
   parameter int DW      = 32,
   parameter int AW      = 3,
   parameter bit REG_EVT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [1:0]    evt_out,
   output logic          pwm_out
);
   localparam int NT = 2;

   if (AW != 3) begin : g_bad_aw
      $error("dual_timer_pwm: AW must be 3");
   end

   ctl_t          ctl_a  [NT];
   logic [CW-1:0] load_a [NT];
   logic [CW-1:0] cnt_a  [NT];
   logic [NT-1:0] tc, rl;
   logic          active;

   assign active = pwm_ready(ctl_a[0]) && pwm_ready(ctl_a[1]);

   for (genvar i = 0; i < NT; i++) begin : g_tmr
      logic sel, sync;
      assign sel = (bus_addr[2] == 1'(i));
      if (i == 0) begin : g_master
         assign sync = 1'b0;
      end else begin : g_follow
         assign sync = active && tc[0];
      end
      dtp_timer #(.CW(CW), .DW(DW), .REG_EVT(REG_EVT)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctl  (bus_we && sel && bus_addr[1:0] == 2'd0),
         .wr_load (bus_we && sel && bus_addr[1:0] == 2'd1),
         .wdata   (bus_wdata),
         .sync_rl (sync),
         .ctl_o   (ctl_a[i]),
         .load_o  (load_a[i]),
         .cnt_o   (cnt_a[i]),
         .tc_o    (tc[i]),
         .rl_o    (rl[i]),
         .evt_o   (evt_out[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr[1:0])
         2'd0:    bus_rdata[CTL_BITS-1:0] = ctl_a[bus_addr[2]];
         2'd1:    bus_rdata[CW-1:0]       = load_a[bus_addr[2]];
         2'd2:    bus_rdata[CW-1:0]       = cnt_a[bus_addr[2]];
         default: bus_rdata = '0;
      endcase
   end

   dtp_pwm_shaper u_shape (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .tc_per  (tc[0]),
      .rl_per  (rl[0]),
      .tc_duty (tc[1]),
      .pwm_o   (pwm_out)
   );

   AST_FOLLOWER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tc[0]) |=> rl[1]);                                    // R7
endmodule

// File: tb/sim_dual_timer_pwm.sv
module sim_dual_timer_pwm;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  evt_out;
   logic        pwm_out;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [31:0] ON  = 32'h3B;  // event, arl, oe, run, pwm
   localparam logic [31:0] LDR = 32'h04;

   localparam int NV = 7;
   localparam int unsigned VEC [NV][2] = '{
      '{10, 4}, '{6, 0}, '{3, 3}, '{5, 9}, '{20, 13}, '{1, 0}, '{0, 5}};

   dual_timer_pwm u0 (.*);

   always #4 clk = ~clk;

   task automatic chk(input string req, input bit ok, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic bw(input logic [2:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wait_rise();
      for (int g = 0; g < 4000 && pwm_out; g++) @(negedge clk);
      for (int g = 0; g < 4000 && !pwm_out; g++) @(negedge clk);
   endtask

   task automatic measure(output int hi, output int per);
      int lo;
      wait_rise();
      hi = 0; lo = 0;
      while (pwm_out && hi < 4000) begin hi++; @(negedge clk); end
      while (!pwm_out && lo < 4000) begin lo++; @(negedge clk); end
      per = hi + lo;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      logic [31:0] d;
      int hi, per, gap;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(3'd0, d); chk("R1 reset ctl0", d == 0, d, 0);
      rd(3'd1, d); chk("R1 reset load0", d == 0, d, 0);
      rd(3'd6, d); chk("R1 reset cnt1", d == 0, d, 0);
      chk("R6 reset pwm", pwm_out == 1'b0, pwm_out, 0);
      chk("R5 reset evt", evt_out == 2'b00, evt_out, 0);

      // R1 readback and unused bits
      bw(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, d); chk("R1 ctl1 readback", d == 32'h7F, d, 32'h7F);
      bw(3'd5, 32'hDEAD_BEEF);
      rd(3'd5, d); chk("R1 load1 readback", d == 32'hDEAD_BEEF, d, 32'hDEAD_BEEF);
      rd(3'd7, d); chk("R1 code 3 zero", d == 0, d, 0);
      bw(3'd4, 32'h0);

      // R2 hold, R3 count
      bw(3'd1, 32'd7);
      bw(3'd0, 32'h14);
      repeat (4) @(negedge clk);
      rd(3'd2, d); chk("R2 hold at load", d == 7, d, 7);
      bw(3'd0, 32'h10);
      repeat (3) @(negedge clk);
      rd(3'd2, d); chk("R3 count down", d == 4, d, 4);

      // R3 wrap without auto-reload
      bw(3'd1, 32'd2);
      bw(3'd0, 32'h14);
      @(negedge clk);
      bw(3'd0, 32'h10);
      repeat (4) @(negedge clk);
      rd(3'd2, d); chk("R3 wrap", d == 32'hFFFF_FFFE, d, 32'hFFFF_FFFE);

      // R4, R5 event pulse spacing L+2
      bw(3'd1, 32'd3);
      bw(3'd0, 32'h14);
      bw(3'd0, 32'h1B);
      for (int g = 0; g < 100 && !evt_out[0]; g++) @(negedge clk);
      @(negedge clk);
      chk("R5 pulse width", evt_out[0] == 1'b0, evt_out[0], 0);
      gap = 1;
      while (!evt_out[0] && gap < 100) begin gap++; @(negedge clk); end
      chk("R4 timer cycle", gap == 5, gap, 5);

      // R5 no pulse without output enable
      bw(3'd0, 32'h13);
      seen = 0;
      for (int g = 0; g < 30; g++) begin @(negedge clk); if (evt_out[0]) seen = 1; end
      chk("R5 oe clear", !seen, seen, 0);

      // vector table: R7 period, R8 high time
      for (int v = 0; v < NV; v++) begin
         int l0, l1, eh, ep;
         l0 = int'(VEC[v][0]); l1 = int'(VEC[v][1]);
         ep = l0 + 2;
         eh = ((l1 < l0) ? l1 : l0) + 1;
         bw(3'd0, LDR); bw(3'd4, LDR);
         bw(3'd1, 32'(l0)); bw(3'd5, 32'(l1));
         bw(3'd0, ON); bw(3'd4, ON);
         measure(hi, per);
         measure(hi, per);
         chk("R7 period", per == ep, per, ep);
         chk("R8 high time", hi == eh, hi, eh);
      end

      // R6: each mode bit wrong in turn
      bw(3'd0, LDR); bw(3'd4, LDR);
      bw(3'd1, 32'd10); bw(3'd5, 32'd4);
      bw(3'd0, ON); bw(3'd4, ON);
      for (int b = 0; b < 7; b++) begin
         logic [2:0] a;
         a = (b % 2 == 1) ? 3'd4 : 3'd0;
         wait_rise();
         bw(a, ON ^ (32'd1 << b));
         seen = 0;
         for (int g = 0; g < 40; g++) begin if (pwm_out) seen = 1; @(negedge clk); end
         chk($sformatf("R6 bit %0d", b), !seen, seen, 0);
         bw(a, ON);
      end

      // R9 staggered update of the two reload values
      bw(3'd0, LDR); bw(3'd4, LDR);
      bw(3'd1, 32'd10); bw(3'd5, 32'd4);
      bw(3'd0, ON); bw(3'd4, ON);
      measure(hi, per);
      wait_rise();
      bw(3'd1, 32'd20);
      wait_rise();
      hi = 0; per = 0;
      while (pwm_out && hi < 4000) begin hi++; @(negedge clk); end
      bw(3'd5, 32'd8);
      per = hi + 1;
      while (!pwm_out && per < 4000) begin per++; @(negedge clk); end
      chk("R9 mixed high", hi == 5, hi, 5);
      chk("R9 mixed period", per == 22, per, 22);
      hi = 0; per = 0;
      while (pwm_out && hi < 4000) begin hi++; @(negedge clk); end
      per = hi;
      while (!pwm_out && per < 4000) begin per++; @(negedge clk); end
      chk("R9 new high", hi == 9, hi, 9);
      chk("R9 new period", per == 22, per, 22);

      summary();
   end
endmodule